// File: doc/BRIEF.md
# Sequential Ones' Complement Multiply/Divide Engine

This block performs 36-bit signed multiplication and division one bit per step, using a shared pair of 36-bit result registers and a step counter. Operands are in ones' complement. The sign bit is bit 35. Bits 34:0 hold the magnitude directly for a positive value and inverted for a negative one. A start pulse captures the operation select and three operand words: the buffer word (multiplicand or divisor), the high word and the low word. When the operation completes, the block raises a one-clock done pulse. The results stay in the register pair until the next accepted start.

For a multiply, the low word holds the multiplier. The high word input is captured but takes no part in the result. The 70-bit magnitude product is then split across the pair: the high 35 bits go to the high register and the low 35 bits go to the low register. Both registers carry the product sign.

For a divide, the pair holds a 70-bit dividend. Its sign is taken from the high word. The quotient ends in the low register and the remainder ends in the high register. A dividend whose high half is too large for the divisor is rejected at once and the pair is left as loaded.

Run time depends on the data. Each step shifts once. A step that adds (multiplier bit one) or subtracts (quotient bit one) costs one extra clock.

Top module: `mdu_top`

## Requirements
- R1: While reset is low, and after it is released, busy, done and overflow are 0 and both result registers read 0.
- R2: Multiply (opDiv=0). With multiplicand magnitude A (from bufIn) and multiplier magnitude B (from ioIn), let P=A*B (70 bits). Let s be the XOR of bit 35 of bufIn and bit 35 of ioIn. Then accOut = {s, P[69:35]} and ioOut = {s, P[34:0]}, with each 35-bit field inverted when s=1.
- R3: Divide (opDiv=0 is multiply, opDiv=1 is divide). The dividend sign is accIn[35]. The dividend magnitude is the 70-bit value {accIn[34:0], ioIn[34:0]}, inverted when that sign is 1. The divisor magnitude D comes from bufIn. The result is ioOut = quotient Q with sign (dividend sign XOR bufIn[35]), and accOut = remainder with the dividend sign. Each field is inverted when its sign is 1.
- R4: A divide whose high dividend magnitude is not below D (this includes D=0) sets overflow together with done. It leaves accOut and ioOut equal to accIn and ioIn. Done rises 1 edge after the start edge.
- R5: A multiply raises done 37+k clock edges after the edge that samples start, where k is the number of one bits in B.
- R6: A completed divide raises done 37+k edges after the start edge, where k is the number of one bits in Q.
- R7: Done is high for exactly one clock. Busy is high from the edge after an accepted start until done rises.
- R8: A start pulse seen while busy is ignored: the running operation's result and timing are unchanged.
- R9: An accepted start clears overflow. Results and overflow hold their values between done and the next accepted start.
- R10: ioIn[35] has no effect on a divide, and accIn has no effect on a multiply.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation when not busy |
| opDiv | input | 1 | 0 = multiply, 1 = divide |
| bufIn | input | 36 | Multiplicand or divisor |
| accIn | input | 36 | High dividend word |
| ioIn | input | 36 | Multiplier or low dividend word |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-clock completion pulse |
| overflow | output | 1 | Divide rejected; valid from done to next start |
| accOut | output | 36 | High product or remainder |
| ioOut | output | 36 | Low product or quotient |

## Verification
Each step, and each extra add or subtract clock, shifts the done edge by one cycle. A wrong step counter or a wrong add/subtract decision is therefore seen as an exact latency mismatch on the same operation, before the result is even examined. A corrupted partial product or partial remainder shows in the result words at that same done pulse. For a divide, the partial-remainder bound is also checked internally after every subtract. Sign handling is exercised with each sign pairing and with negative zero. The outputs and overflow are watched after done, to confirm that they hold and that a start raised during a run leaves it undisturbed.

// File: rtl/mdu_pkg.sv
package mdu_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PREP,
    ST_MBIT,
    ST_MSH,
    ST_DBIT,
    ST_DSUB,
    ST_FIX
  } mduState_t;

  // strobes from the sequencer to the datapath; at most one action bit per cycle
  typedef struct packed {
    logic capture;
    logic prep;
    logic isDiv;
    logic addStep;
    logic shiftRight;
    logic shiftLeft;
    logic subStep;
    logic finish;
  } mduCtl_t;

endpackage

// File: rtl/mdu_ctrl.sv
module mdu_ctrl
  import mdu_pkg::*;
#(
  parameter int MAG = 35
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    start,
  input  logic    opDiv,
  input  logic    loLsb,
  input  logic    remGe,
  input  logic    divOvf,
  output mduCtl_t ctl,
  output logic    busy,
  output logic    done,
  output logic    overflow
);

  localparam int CNTW = $clog2(MAG + 1);

  mduState_t state, nxt;
  logic [CNTW-1:0] cnt;
  logic isDivQ;
  logic doneQ;
  logic ovfQ;
  logic lastCnt;
  logic rejectNow;

  assign lastCnt   = (cnt == CNTW'(1));
  assign rejectNow = (state == ST_PREP) && isDivQ && divOvf;

  always_comb begin
    nxt = state;
    ctl = '0;
    ctl.isDiv = isDivQ;
    case (state)
      ST_IDLE: begin
        if (start) begin
          ctl.capture = 1'b1;
          nxt = ST_PREP;
        end
      end
      ST_PREP: begin
        if (rejectNow) begin
          nxt = ST_IDLE;
        end else begin
          ctl.prep = 1'b1;
          nxt = isDivQ ? ST_DBIT : ST_MBIT;
        end
      end
      ST_MBIT: begin
        if (loLsb) begin
          ctl.addStep = 1'b1;
          nxt = ST_MSH;
        end else begin
          ctl.shiftRight = 1'b1;
          nxt = lastCnt ? ST_FIX : ST_MBIT;
        end
      end
      ST_MSH: begin
        ctl.shiftRight = 1'b1;
        nxt = lastCnt ? ST_FIX : ST_MBIT;
      end
      ST_DBIT: begin
        ctl.shiftLeft = 1'b1;
        if (remGe) nxt = ST_DSUB;
        else       nxt = lastCnt ? ST_FIX : ST_DBIT;
      end
      ST_DSUB: begin
        ctl.subStep = 1'b1;
        nxt = (cnt == '0) ? ST_FIX : ST_DBIT;
      end
      ST_FIX: begin
        ctl.finish = 1'b1;
        nxt = ST_IDLE;
      end
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      cnt    <= '0;
      isDivQ <= 1'b0;
      doneQ  <= 1'b0;
      ovfQ   <= 1'b0;
    end else begin
      state <= nxt;
      doneQ <= (state == ST_FIX) || rejectNow;
      if (ctl.capture) begin
        isDivQ <= opDiv;
        ovfQ   <= 1'b0;
      end
      if (rejectNow) ovfQ <= 1'b1;
      if (ctl.prep) cnt <= CNTW'(MAG);
      else if (ctl.shiftRight || ctl.shiftLeft) cnt <= cnt - CNTW'(1);
    end
  end

  assign busy     = (state != ST_IDLE);
  assign done     = doneQ;
  assign overflow = ovfQ;

  assert_done_single_R7: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  assert_busy_after_start_R7: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy) |=> busy);

  assert_start_ignored_R8: assert property (@(posedge clk) disable iff (!rstN)
    (busy && start && state != ST_FIX) |=> busy);

  assert_ovf_with_done_R4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(overflow) |-> done);

  assert_cnt_range_R5: assert property (@(posedge clk) disable iff (!rstN)
    cnt <= CNTW'(MAG));

endmodule

// File: rtl/mdu_datapath.sv
module mdu_datapath
  import mdu_pkg::*;
#(
  parameter int WIDTH = 36
) (
  input  logic             clk,
  input  logic             rstN,
  input  mduCtl_t          ctl,
  input  logic [WIDTH-1:0] bufIn,
  input  logic [WIDTH-1:0] accIn,
  input  logic [WIDTH-1:0] ioIn,
  output logic             loLsb,
  output logic             remGe,
  output logic             divOvf,
  output logic [WIDTH-1:0] accOut,
  output logic [WIDTH-1:0] ioOut
);

  localparam int MAG = WIDTH - 1;

  logic [WIDTH-1:0] accQ, ioQ, bufR;
  logic [MAG:0]     hiW;       // one spare bit for add carry / trial remainder
  logic [MAG-1:0]   loW;
  logic [MAG-1:0]   magW;
  logic             sOp, sData;
  logic [MAG:0]     shiftedRem;
  logic [MAG:0]     magExt;
  logic             resSign;

  function automatic logic [MAG-1:0] magOf(input logic [WIDTH-1:0] w);
    return w[MAG] ? ~w[MAG-1:0] : w[MAG-1:0];
  endfunction

  function automatic logic [WIDTH-1:0] packSigned(input logic s, input logic [MAG-1:0] m);
    return {s, s ? ~m : m};
  endfunction

  assign magExt     = {1'b0, magW};
  assign shiftedRem = {hiW[MAG-1:0], loW[MAG-1]};
  assign remGe      = (shiftedRem >= magExt);
  assign loLsb      = loW[0];
  assign divOvf     = (magOf(accQ) >= magOf(bufR));
  assign resSign    = sOp ^ sData;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      accQ  <= '0;
      ioQ   <= '0;
      bufR  <= '0;
      hiW   <= '0;
      loW   <= '0;
      magW  <= '0;
      sOp   <= 1'b0;
      sData <= 1'b0;
    end else if (ctl.capture) begin
      accQ <= accIn;
      ioQ  <= ioIn;
      bufR <= bufIn;
    end else if (ctl.prep) begin
      sOp  <= bufR[MAG];
      magW <= magOf(bufR);
      if (ctl.isDiv) begin
        sData <= accQ[MAG];
        hiW   <= {1'b0, magOf(accQ)};
        loW   <= ioQ[MAG-1:0] ^ {MAG{accQ[MAG]}};
      end else begin
        sData <= ioQ[MAG];
        hiW   <= '0;
        loW   <= magOf(ioQ);
      end
    end else if (ctl.addStep) begin
      hiW <= hiW + magExt;
    end else if (ctl.shiftRight) begin
      hiW <= {1'b0, hiW[MAG:1]};
      loW <= {hiW[0], loW[MAG-1:1]};
    end else if (ctl.shiftLeft) begin
      hiW <= shiftedRem;
      loW <= {loW[MAG-2:0], 1'b0};
    end else if (ctl.subStep) begin
      hiW <= hiW - magExt;
      loW <= loW | MAG'(1);
    end else if (ctl.finish) begin
      if (ctl.isDiv) begin
        ioQ  <= packSigned(resSign, loW);
        accQ <= packSigned(sData, hiW[MAG-1:0]);
      end else begin
        accQ <= packSigned(resSign, hiW[MAG-1:0]);
        ioQ  <= packSigned(resSign, loW);
      end
    end
  end

  assign accOut = accQ;
  assign ioOut  = ioQ;

  assert_rem_below_divisor_R3: assert property (@(posedge clk) disable iff (!rstN)
    ctl.subStep |=> (hiW < magExt));

  assert_hold_outputs_R9: assert property (@(posedge clk) disable iff (!rstN)
    (!ctl.capture && !ctl.finish) |=> ($stable(accQ) && $stable(ioQ)));

endmodule

// File: rtl/mdu_top.sv
module mdu_top
  import mdu_pkg::*;
#(
  parameter int WIDTH = 36
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic             opDiv,
  input  logic [WIDTH-1:0] bufIn,
  input  logic [WIDTH-1:0] accIn,
  input  logic [WIDTH-1:0] ioIn,
  output logic             busy,
  output logic             done,
  output logic             overflow,
  output logic [WIDTH-1:0] accOut,
  output logic [WIDTH-1:0] ioOut
);

  localparam int MAG = WIDTH - 1;

  mduCtl_t ctl;
  logic loLsb, remGe, divOvf;

  mdu_ctrl #(.MAG(MAG)) ctrl_i (
    .clk(clk), .rstN(rstN), .start(start), .opDiv(opDiv),
    .loLsb(loLsb), .remGe(remGe), .divOvf(divOvf),
    .ctl(ctl), .busy(busy), .done(done), .overflow(overflow)
  );

  mdu_datapath #(.WIDTH(WIDTH)) dp_i (
    .clk(clk), .rstN(rstN), .ctl(ctl),
    .bufIn(bufIn), .accIn(accIn), .ioIn(ioIn),
    .loLsb(loLsb), .remGe(remGe), .divOvf(divOvf),
    .accOut(accOut), .ioOut(ioOut)
  );

endmodule

// File: tb/mdu_top_tb_top.sv
`timescale 1ns/1ps
module mdu_top_tb_top;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic opDiv = 1'b0;
  logic [35:0] bufIn = '0, accIn = '0, ioIn = '0;
  logic busy, done, overflow;
  logic [35:0] accOut, ioOut;

  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  mdu_top dut_i (
    .clk(clk), .rstN(rstN), .start(start), .opDiv(opDiv),
    .bufIn(bufIn), .accIn(accIn), .ioIn(ioIn),
    .busy(busy), .done(done), .overflow(overflow),
    .accOut(accOut), .ioOut(ioOut)
  );

  task automatic check(input string tag, input logic [71:0] act, input logic [71:0] exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [34:0] magOf(input logic [35:0] w);
    return w[35] ? ~w[34:0] : w[34:0];
  endfunction

  function automatic logic [35:0] packS(input logic s, input logic [34:0] m);
    return {s, s ? ~m : m};
  endfunction

  // run one operation; interfere pulses start mid-run with other operands
  task automatic runOp(input string name, input logic isDiv, input logic [35:0] a,
                       input logic [35:0] b, input logic [35:0] m, input bit interfere);
    logic [34:0] ma, mb, d;
    logic [69:0] p, dv, q, r;
    logic s, sd, sq, expOvf;
    logic [35:0] expAcc, expIo;
    int expCnt, cnt;
    bit got;
    logic [35:0] holdAcc;
    if (!isDiv) begin
      ma = magOf(m); mb = magOf(b);
      p = 70'(ma) * 70'(mb);
      s = m[35] ^ b[35];
      expAcc = packS(s, p[69:35]);
      expIo  = packS(s, p[34:0]);
      expOvf = 1'b0;
      expCnt = 38 + $countones(mb);
    end else begin
      sd = a[35];
      dv = {a[34:0], b[34:0]} ^ {70{sd}};
      d  = magOf(m);
      expOvf = (dv[69:35] >= d);
      if (expOvf) begin
        expAcc = a; expIo = b; expCnt = 2;
      end else begin
        q = dv / 70'(d);
        r = dv % 70'(d);
        sq = sd ^ m[35];
        expIo  = packS(sq, q[34:0]);
        expAcc = packS(sd, r[34:0]);
        expCnt = 38 + $countones(q);
      end
    end
    @(negedge clk);
    start = 1'b1; opDiv = isDiv; accIn = a; ioIn = b; bufIn = m;
    cnt = 0; got = 0;
    while (!got && cnt < 300) begin
      @(posedge clk);
      cnt++;
      @(negedge clk);
      if (cnt == 1) begin
        start = 1'b0;
        check({name, " R7 busy after start"}, 72'(busy), 72'(1));
        check({name, " R9 overflow cleared by start"}, 72'(overflow), 72'(0));
      end
      if (interfere && cnt == 5) begin
        start = 1'b1; opDiv = ~isDiv; accIn = ~a; ioIn = ~b; bufIn = 36'h1;
      end
      if (interfere && cnt == 6) start = 1'b0;
      if (done) got = 1;
    end
    check({name, isDiv ? " R6/R4 latency" : " R5 latency"}, 72'(cnt), 72'(expCnt));
    check({name, isDiv ? " R3 remainder acc" : " R2 high product acc"}, 72'(accOut), 72'(expAcc));
    check({name, isDiv ? " R3 quotient io" : " R2 low product io"}, 72'(ioOut), 72'(expIo));
    check({name, " R4 overflow flag"}, 72'(overflow), 72'(expOvf));
    holdAcc = accOut;
    repeat (3) @(negedge clk);
    check({name, " R7 done single clock"}, 72'(done), 72'(0));
    check({name, " R9 results hold"}, 72'({holdAcc, ioOut}), 72'({expAcc, expIo}));
    check({name, " R9 overflow holds"}, 72'(overflow), 72'(expOvf));
  endtask

  task automatic testReset();
    repeat (3) @(negedge clk);
    check("R1 reset busy/done/ovf low", 72'({busy, done, overflow}), 72'(0));
    rstN = 1'b1;
    @(negedge clk);
    check("R1 reset results zero", 72'({accOut, ioOut}), 72'(0));
  endtask

  task automatic testMultiply();
    runOp("mul pos*pos", 1'b0, 36'h0, 36'd5, 36'd3, 0);
    runOp("mul neg*pos", 1'b0, 36'h0, 36'd12345, ~36'd678, 0);
    runOp("mul neg*neg", 1'b0, 36'h0, ~36'h123456789, ~36'h0ABCDEF01, 0);
    runOp("mul max magnitudes", 1'b0, 36'h0, 36'h7FFFFFFFF, 36'h7FFFFFFFF, 0);
    runOp("mul zero multiplier", 1'b0, 36'h0, 36'h0, 36'h55555, 0);
    runOp("mul negative zero multiplier", 1'b0, 36'h0, 36'hFFFFFFFFF, 36'd9, 0);
    runOp("mul R10 acc ignored", 1'b0, 36'hDEADBEEF1, 36'd77, 36'd1001, 0);
  endtask

  task automatic testDivide();
    runOp("div pos", 1'b1, 36'h0, 36'd1000, 36'd7, 0);
    runOp("div neg dividend", 1'b1, ~36'h000000012, ~36'h345678901, 36'd99991, 0);
    runOp("div neg divisor", 1'b1, 36'h000000003, 36'h0FFFF0000, ~36'h000012345, 0);
    runOp("div max quotient", 1'b1, 36'h000001233, 36'h7FFFFFFFF, 36'h000001234, 0);
    runOp("div R10 low sign ignored", 1'b1, 36'h0, 36'h800001000, 36'd3, 0);
  endtask

  task automatic testOverflow();
    runOp("div ovf equal", 1'b1, 36'd50, 36'd9, 36'd50, 0);
    runOp("div ovf zero divisor", 1'b1, 36'd0, 36'd9, 36'd0, 0);
    runOp("div after ovf", 1'b1, 36'd1, 36'd4, 36'd50, 0);
  endtask

  task automatic testBusyIgnore();
    runOp("mul R8 start while busy", 1'b0, 36'h0, 36'h3C3C3C3C3, 36'h123, 1);
    runOp("div R8 start while busy", 1'b1, 36'h5, 36'h222222222, 36'h1000, 1);
  endtask

  initial begin
    testReset();
    testMultiply();
    testDivide();
    testOverflow();
    testBusyIgnore();
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      testsRun++;
      testsFailed++;
      $display("FAIL watchdog expired actual=hung expected=complete");
      $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

endmodule